// File: doc/BRIEF.md
# Byte and Word Load/Store Alignment Unit

This unit sits between a core's address stage and a data memory that is one 32-bit word wide but addressed in bytes. In the cycle a request is presented it forms the effective address from a base register value and a signed 16-bit byte offset. It drives the word address, the write data and a write enable for each byte lane.

For loads, the memory is expected to return the addressed word in the following cycle. The unit then picks the whole word, or one byte of it, and widens the byte with either sign or zero fill.

Word accesses must be aligned to a multiple of four bytes. A misaligned word store writes nothing. A misaligned word load produces no result. In both cases a one-cycle error flag is raised in the cycle after the request.

Top module: `lsalign_unit`

## Requirements
- R1: In the request cycle, the effective address equals `base_addr` plus `offset` sign-extended from 16 bits. `mem_addr` carries this address with bits 1:0 cleared.
- R2: An aligned word store (`req_byte`=0, effective address bits 1:0 = 00) drives `mem_we`=1111 and `mem_wdata`=`st_data` in the request cycle.
- R3: A byte store drives bits 7:0 of `st_data` onto all four byte lanes of `mem_wdata`. It sets exactly one `mem_we` bit. Lanes are numbered big-endian: address bits 1:0 = 0, 1, 2, 3 select `mem_we` bit 3, 2, 1, 0, and `mem_we` bit i enables data bits 8i+7:8i.
- R4: A word store whose effective address bits 1:0 are not 00 drives `mem_we`=0000.
- R5: `misalign_err` is high in the cycle after a request for exactly one cycle for each word access (load or store) whose effective address bits 1:0 are not 00. It stays low after byte accesses, aligned accesses and idle cycles.
- R6: An aligned word load raises `ld_valid` in the following cycle. In that cycle `ld_data` equals `mem_rdata`.
- R7: A signed byte load (`req_unsigned`=0) returns, in the following cycle, the byte of `mem_rdata` chosen by address bits 1:0 (0 selects bits 31:24, 3 selects bits 7:0) in `ld_data` bits 7:0. Bit 7 of that byte is copied into bits 31:8.
- R8: An unsigned byte load (`req_unsigned`=1) returns the same selected byte with bits 31:8 zero.
- R9: Loads and idle cycles drive `mem_we`=0000. A misaligned word load leaves `ld_valid` low in the following cycle.
- R10: While reset is held, and until its synchronised release, `ld_valid` and `misalign_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_unsigned | input | 1 | Byte loads: 1 = zero fill, 0 = sign fill |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed byte offset from the instruction |
| st_data | input | 32 | Store source register value |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data, arranged by byte lane |
| mem_we | output | 4 | Write enable per byte lane |
| mem_rdata | input | 32 | Word returned by memory one cycle after a load request |
| ld_valid | output | 1 | Load result is valid this cycle |
| ld_data | output | 32 | Extracted and extended load result |
| misalign_err | output | 1 | One-cycle flag for a misaligned word access |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, which gives four byte lanes and a two-bit lane select, and a 16-bit offset. With these values it can reach every lane for byte stores and for signed and unsigned byte loads. It can also reach each of the three misaligned low-address patterns for word accesses. Negative offsets whose sign bit must carry into the upper address bits are within reach too. Back-to-back misaligned requests show that the error flag stays high across consecutive cycles. A misaligned load is shown to raise the flag without producing a result.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } acc_size_e;

  typedef enum logic {
    FILL_SIGN = 1'b0,
    FILL_ZERO = 1'b1
  } fill_e;
endpackage

// File: rtl/lsa_ea_gen.sv
module lsa_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFS_W-1:0] offs,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] offs_ext;

  assign offs_ext = {{EXT_W{offs[OFFS_W-1]}}, offs};
  assign ea       = base + offs_ext;
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      en,
  input  acc_size_e                 size,
  input  logic                      blk,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [DATA_W-1:0]         din,
  output logic [DATA_W-1:0]         wdata,
  output logic [DATA_W/8-1:0]       we
);
  localparam int LANES = DATA_W / 8;
  localparam int LSW   = $clog2(LANES);

  assign wdata = (size == SZ_BYTE) ? {LANES{din[7:0]}} : din;

  // lane g (big-endian) lives in the bus slot LANES-1-g
  for (genvar g = 0; g < LANES; g++) begin : g_we
    logic hit;
    assign hit = (size == SZ_WORD) ? ~blk : (lane == LSW'(g));
    assign we[LANES-1-g] = en & hit;
  end
endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           rdata,
  input  acc_size_e                   size,
  input  fill_e                       fill,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  output logic [DATA_W-1:0]           result
);
  localparam int LANES = DATA_W / 8;

  logic [7:0] lane_byte [LANES];
  logic [7:0] sel;
  logic       top_bit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = rdata[DATA_W-1-8*g -: 8];
  end

  assign sel     = lane_byte[lane];
  assign top_bit = (fill == FILL_SIGN) & sel[7];

  always_comb begin
    if (size == SZ_WORD) result = rdata;
    else                 result = {{(DATA_W-8){top_bit}}, sel};
  end
endmodule

// File: rtl/lsalign_unit.sv
module lsalign_unit
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic              req_byte,
  input  logic              req_unsigned,
  input  logic [DATA_W-1:0] base_addr,
  input  logic [OFFS_W-1:0] offset,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  output logic              misalign_err
);
  localparam int LANES = DATA_W / 8;
  localparam int LSW   = $clog2(LANES);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // request decode
  logic [DATA_W-1:0] ea;
  logic [LSW-1:0]    lane;
  acc_size_e         size;
  fill_e             fill;
  logic              misal;

  lsa_ea_gen #(.ADDR_W(DATA_W), .OFFS_W(OFFS_W)) u_ea (
    .base (base_addr),
    .offs (offset),
    .ea   (ea)
  );

  assign lane     = ea[LSW-1:0];
  assign size     = req_byte ? SZ_BYTE : SZ_WORD;
  assign fill     = req_unsigned ? FILL_ZERO : FILL_SIGN;
  assign misal    = (size == SZ_WORD) && (lane != '0);
  assign mem_addr = {ea[DATA_W-1:LSW], {LSW{1'b0}}};

  lsa_store_lane #(.DATA_W(DATA_W)) u_st (
    .en    (req_valid & req_store),
    .size  (size),
    .blk   (misal),
    .lane  (lane),
    .din   (st_data),
    .wdata (mem_wdata),
    .we    (mem_we)
  );

  // load context and error flag: next state
  logic           ldv_d, ldv_q;
  logic           err_d, err_q;
  logic           ctx_en;
  logic [LSW-1:0] lane_q;
  acc_size_e      size_q;
  fill_e          fill_q;

  always_comb begin
    ldv_d  = req_valid & ~req_store & ~misal;
    err_d  = req_valid & misal;
    ctx_en = ldv_d;
  end

  // load context and error flag: registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ldv_q  <= 1'b0;
      err_q  <= 1'b0;
      lane_q <= '0;
      size_q <= SZ_WORD;
      fill_q <= FILL_SIGN;
    end else begin
      ldv_q <= ldv_d;
      err_q <= err_d;
      if (ctx_en) begin
        lane_q <= lane;
        size_q <= size;
        fill_q <= fill;
      end
    end
  end

  lsa_load_ext #(.DATA_W(DATA_W)) u_ld (
    .rdata  (mem_rdata),
    .size   (size_q),
    .fill   (fill_q),
    .lane   (lane_q),
    .result (ld_data)
  );

  assign ld_valid     = ldv_q;
  assign misalign_err = err_q;

  // checks beside the logic they guard
  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_store && req_byte) |-> ($countones(mem_we) == 1));

  a_r4_no_write_misaligned: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_store && !req_byte && ea[LSW-1:0] != '0) |-> (mem_we == '0));

  a_r9_load_no_write: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!req_valid || !req_store) |-> (mem_we == '0));

  a_r5_err_has_cause: assert property (@(posedge clk) disable iff (!rst_q_n)
    misalign_err |-> $past(req_valid && !req_byte && ea[LSW-1:0] != '0));

  a_r6_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_valid |-> $past(req_valid && !req_store));

  a_r9_no_result_on_error: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(ld_valid && misalign_err));

  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_valid && size_q == SZ_BYTE && fill_q == FILL_ZERO) |-> (ld_data[DATA_W-1:8] == '0));
endmodule

// File: tb/sim_lsalign_unit.sv
`timescale 1ns/100ps
module sim_lsalign_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_byte, req_unsigned;
  logic [31:0] base_addr, st_data, mem_rdata;
  logic [15:0] offset;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_we;
  logic        ld_valid, misalign_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    bit          v;
    bit          e;
    logic [31:0] d;
  } exp_t;
  exp_t        sb[$];
  logic [31:0] pend_rd = 32'h0;

  always #2 clk = ~clk;

  lsalign_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_byte(req_byte), .req_unsigned(req_unsigned), .base_addr(base_addr),
    .offset(offset), .st_data(st_data), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .misalign_err(misalign_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: one cycle per call; checks request-cycle outputs, queues the next-cycle result
  task automatic step(input bit v, input bit st, input bit by, input bit un,
                      input logic [31:0] b, input logic [15:0] o,
                      input logic [31:0] sd, input logic [31:0] rd);
    logic [31:0] ea, exp_wd, xd;
    logic [3:0]  exp_we;
    logic [1:0]  ln;
    logic [7:0]  bt;
    exp_t        it;
    @(negedge clk);
    req_valid = v; req_store = st; req_byte = by; req_unsigned = un;
    base_addr = b; offset = o; st_data = sd; mem_rdata = pend_rd;
    pend_rd = rd;
    ea = b + {{16{o[15]}}, o};
    ln = ea[1:0];
    if (!v || !st)   exp_we = 4'b0000;
    else if (by)     exp_we = 4'b1000 >> ln;
    else             exp_we = (ln == 2'd0) ? 4'b1111 : 4'b0000;
    exp_wd = by ? {4{sd[7:0]}} : sd;
    #1;
    if (v) chk(mem_addr == {ea[31:2], 2'b00}, "R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk(mem_we == exp_we, (v && st) ? (by ? "R3 mem_we" : "R2/R4 mem_we") : "R9 mem_we",
        {28'h0, mem_we}, {28'h0, exp_we});
    if (exp_we != 4'b0000)
      chk(mem_wdata == exp_wd, by ? "R3 mem_wdata" : "R2 mem_wdata", mem_wdata, exp_wd);
    bt = rd[31 - 8*ln -: 8];
    xd = by ? (un ? {24'h0, bt} : {{24{bt[7]}}, bt}) : rd;
    it.v = v && !st && (by || ln == 2'd0);
    it.e = v && !by && ln != 2'd0;
    it.d = xd;
    #0.5;
    sb.push_back(it);
  endtask

  // monitor: pops one expected item per cycle and compares
  always begin
    exp_t it;
    @(negedge clk);
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      chk(ld_valid == it.v, "R6/R9 ld_valid", {31'h0, ld_valid}, {31'h0, it.v});
      chk(misalign_err == it.e, "R5 misalign_err", {31'h0, misalign_err}, {31'h0, it.e});
      if (it.v) chk(ld_data == it.d, "R6/R7/R8 ld_data", ld_data, it.d);
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_store = 0; req_byte = 0; req_unsigned = 0;
    base_addr = 0; offset = 0; st_data = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    #1;
    // R10: outputs quiet while reset held
    chk(ld_valid == 1'b0, "R10 ld_valid", {31'h0, ld_valid}, 32'h0);
    chk(misalign_err == 1'b0, "R10 misalign_err", {31'h0, misalign_err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);

    // R1/R2: aligned word stores, positive and negative offsets
    step(1, 1, 0, 0, 32'h0000_1000, 16'h0004, 32'hDEAD_BEEF, 0);
    step(1, 1, 0, 0, 32'h0000_0010, 16'hFFF0, 32'h1234_5678, 0);
    step(1, 1, 0, 0, 32'h0001_0000, 16'h8000, 32'hA5A5_0F0F, 0);
    // R4/R5: misaligned word stores, back to back
    for (int k = 1; k < 4; k++) step(1, 1, 0, 0, 32'h0000_2000, 16'(k), 32'hFFFF_FFFF, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R3: byte stores on every lane, including a negative offset
    for (int k = 0; k < 4; k++) step(1, 1, 1, 0, 32'h0000_3000, 16'(k), 32'h1122_33C4 + k, 0);
    step(1, 1, 1, 0, 32'h0000_3003, 16'hFFFD, 32'h0000_0077, 0);
    // R6: aligned word loads
    step(1, 0, 0, 0, 32'h0000_4000, 16'h0008, 0, 32'hCAFE_F00D);
    step(1, 0, 0, 1, 32'h0000_4010, 16'hFFFC, 0, 32'h8000_0001);
    // R5/R9: misaligned word loads give no result
    step(1, 0, 0, 0, 32'h0000_4000, 16'h0002, 0, 32'h1111_1111);
    step(1, 0, 0, 0, 32'h0000_4000, 16'h0003, 0, 32'h2222_2222);
    // R7: signed byte loads on every lane
    for (int k = 0; k < 4; k++) step(1, 0, 1, 0, 32'h0000_5000, 16'(k), 0, 32'h807F_C301);
    // R8: unsigned byte loads on every lane
    for (int k = 0; k < 4; k++) step(1, 0, 1, 1, 32'h0000_5000, 16'(k), 0, 32'h807F_C301);
    // R5: byte access at odd address raises no error
    step(1, 0, 1, 0, 32'h0000_5001, 16'h0002, 0, 32'hFF00_FF00);
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    finish_up();
  end
endmodule